// File: doc/BRIEF.md
# Tri-State PWM Gate Decoder

This block turns a three-level PWM command into the two gate-enable signals of a synchronous buck power stage. The analog PWM pin is presented as two comparator flags: one set while the pin is above the rising threshold, one set while it is below the falling threshold. A high level turns on the high-side gate, and a low level turns on the low-side gate. An input that dwells between the thresholds for a programmed number of clock cycles is read as a released, high-impedance line. The block then switches both gates off and holds them off until a valid high arrives.

Around that decoder sit three gating functions. A global enable forces both gates off. A low-side enable forces only the low-side gate off, which gives diode-emulation operation in discontinuous conduction. A break-before-make stage keeps both gates low for a programmed dead time whenever a conducting gate switches off. The flags are resynchronised through two flops. The enables are taken as synchronous to the block clock. A status output reports when the tri-state-off condition is active.

Top module: `tristate_pwm_gate`

## Requirements
- R1: When the synchronised input is a valid high, the block drives high-side gate on and low-side gate off. Valid high means above_i=1, and it also holds when both flags are 1. A change at the pins reaches the gate outputs on the fourth rising clock edge.
- R2: When the synchronised input is a valid low (above_i=0, below_i=1) and tri-state-off is not active, the block drives low-side gate on and high-side gate off.
- R3: A mid-window input (both flags 0) on HOLD_CYCLES consecutive synchronised samples asserts tri_off_o, on the third edge after the last such sample reaches the pins. On the following edge both gates go off.
- R4: A mid-window excursion shorter than HOLD_CYCLES samples restarts the dwell count, does not assert tri_off_o, and leaves the gates in the state set by the last valid level.
- R5: Once tri_off_o is set, only a valid high clears it. A valid low leaves it set and both gates off.
- R6: After reset, tri_off_o is 1 and both gates are 0. This holds, with the input low or mid, until the first valid high.
- R7: While ls_enable_i is 0, the low-side gate is forced off, and the high-side gate still follows a valid high.
- R8: While enable_i is 0, both gates are forced off. Enable is sampled at the edge that updates the gates.
- R9: The two gates are never on together. After any gate turns off, neither gate turns on until both have been low for DEAD_CYCLES clock cycles.
- R10: tri_off_o is 1 exactly while the tri-state-off condition is in force. It is cleared on the third edge after a valid high reaches the pins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous reset, active low |
| above_i | input | 1 | Comparator flag: PWM pin above rising threshold (asynchronous) |
| below_i | input | 1 | Comparator flag: PWM pin below falling threshold (asynchronous) |
| enable_i | input | 1 | Global enable, 0 forces both gates off |
| ls_enable_i | input | 1 | Low-side enable, 0 forces the low-side gate off |
| hs_gate_o | output | 1 | High-side gate enable |
| ls_gate_o | output | 1 | Low-side gate enable |
| tri_off_o | output | 1 | Tri-state-off condition active |

## Verification
The bench builds the block with HOLD_CYCLES=5 and DEAD_CYCLES=3. With these values, excursions of three and four mid-window samples test the off-by-one edge of the dwell counter, and a five-sample dwell reaches tri-state entry within a few cycles. A three-cycle dead time is long enough that a gate request can flip while the gap is still running. A behavioural model runs the same stimulus, including a long stretch of random flag patterns, and is compared with the outputs on every clock.

// File: rtl/tsd_pkg.sv
// Package: shared types and the level decode used by the tri-state PWM gate decoder.
// Assumes the two comparator flags are already synchronised when decoded.
package tsd_pkg;

    typedef enum logic [1:0] {
        LVL_MID  = 2'd0,
        LVL_LOW  = 2'd1,
        LVL_HIGH = 2'd2
    } lvl_e;

    // Map the two flags to a level; both flags set counts as high.
    function automatic lvl_e decode_level(input logic above, input logic below);
        if (above) begin
            return LVL_HIGH;
        end else if (below) begin
            return LVL_LOW;
        end
        return LVL_MID;
    endfunction

endpackage

// File: rtl/tsd_sync.sv
// Module: multi-flop synchroniser for a bus of independent asynchronous flags.
// Assumes each bit is an unrelated level signal (no bus coherency needed).
module tsd_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);

    logic [WIDTH-1:0] stage_q [STAGES];

    genvar gi;
    generate
        for (gi = 0; gi < STAGES; gi++) begin : g_stage
            if (gi == 0) begin : g_first
                // First flop captures the asynchronous pins.
                always_ff @(posedge clk) begin
                    if (!rst_n) stage_q[gi] <= '0;
                    else        stage_q[gi] <= async_i;
                end
            end else begin : g_next
                // Later flops settle metastability.
                always_ff @(posedge clk) begin
                    if (!rst_n) stage_q[gi] <= '0;
                    else        stage_q[gi] <= stage_q[gi-1];
                end
            end
        end
    endgenerate

    assign sync_o = stage_q[STAGES-1];

endmodule

// File: rtl/tsd_level_track.sv
// Module: tracks the last valid PWM level and detects the tri-state condition.
// A mid-window level held for HOLD_CYCLES samples sets tri_off; only a high
// level clears it. Reset enters tri_off. Assumes synchronised flags.
module tsd_level_track
    import tsd_pkg::*;
#(
    parameter int HOLD_CYCLES = 13
) (
    input  logic clk,
    input  logic rst_n,
    input  logic above_s,
    input  logic below_s,
    output logic tri_off_o,
    output logic last_hi_o
);

    localparam int CW = (HOLD_CYCLES > 1) ? $clog2(HOLD_CYCLES) : 1;
    localparam logic [CW-1:0] DWELL_LAST = CW'(HOLD_CYCLES - 1);
    localparam int RW = $clog2(HOLD_CYCLES + 1);
    localparam logic [RW-1:0] RUN_MAX = RW'(HOLD_CYCLES);

    lvl_e          lvl;
    logic [CW-1:0] dwell_q;

    // Decode the synchronised flags into a level.
    always_comb lvl = decode_level(above_s, below_s);

    // Update the tri-state flag, dwell counter and last valid level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tri_off_o <= 1'b1;
            last_hi_o <= 1'b0;
            dwell_q   <= '0;
        end else begin
            case (lvl)
                LVL_HIGH: begin
                    tri_off_o <= 1'b0;
                    last_hi_o <= 1'b1;
                    dwell_q   <= '0;
                end
                LVL_LOW: begin
                    last_hi_o <= 1'b0;
                    dwell_q   <= '0;
                end
                default: begin
                    if (dwell_q == DWELL_LAST) tri_off_o <= 1'b1;
                    else                       dwell_q   <= dwell_q + 1'b1;
                end
            endcase
        end
    end

    // Checker state: independent run length of consecutive mid samples.
    logic [RW-1:0] mid_run_q;
    always_ff @(posedge clk) begin
        if (!rst_n)                mid_run_q <= '0;
        else if (lvl != LVL_MID)   mid_run_q <= '0;
        else if (mid_run_q != RUN_MAX) mid_run_q <= mid_run_q + 1'b1;
    end

    // R3: entry happens only after a full hold-off dwell.
    p_dwell_entry_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tri_off_o) |-> (mid_run_q == RUN_MAX));

    // R4: a valid level never sets the tri-state flag.
    p_no_entry_on_valid_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!tri_off_o && lvl != LVL_MID) |=> !tri_off_o);

    // R5: only a high level releases the flag.
    p_exit_on_high_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(tri_off_o) |-> $past(lvl == LVL_HIGH));

    // R5: a low level keeps the flag set.
    p_low_keeps_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (tri_off_o && lvl == LVL_LOW) |=> tri_off_o);

endmodule

// File: rtl/tsd_deadtime.sv
// Module: break-before-make stage for the two gate requests.
// Any gate turning off starts a gap of DEAD_CYCLES cycles with both low before
// either gate may turn on. Assumes the two requests are never both set.
module tsd_deadtime #(
    parameter int DEAD_CYCLES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req_hs_i,
    input  logic req_ls_i,
    output logic hs_o,
    output logic ls_o
);

    localparam int DW = (DEAD_CYCLES > 1) ? $clog2(DEAD_CYCLES) : 1;
    localparam logic [DW-1:0] GAP_LOAD = DW'(DEAD_CYCLES - 1);
    localparam int LW = $clog2(DEAD_CYCLES + 1);
    localparam logic [LW-1:0] LOW_MAX = LW'(DEAD_CYCLES);

    logic [DW-1:0] gap_q;
    logic          drop;

    // A conducting gate whose request went away must switch off.
    always_comb drop = (hs_o && !req_hs_i) || (ls_o && !req_ls_i);

    // Sequence gate turn-off, dead-time countdown and gate turn-on.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hs_o  <= 1'b0;
            ls_o  <= 1'b0;
            gap_q <= '0;
        end else if (drop) begin
            hs_o  <= 1'b0;
            ls_o  <= 1'b0;
            gap_q <= GAP_LOAD;
        end else if (!hs_o && !ls_o) begin
            if (gap_q != '0)  gap_q <= gap_q - 1'b1;
            else if (req_hs_i) hs_o <= 1'b1;
            else if (req_ls_i) ls_o <= 1'b1;
        end
    end

    // Checker state: cycles both gates have been low, and whether any gate was on.
    logic [LW-1:0] low_run_q;
    logic          seen_on_q;
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            low_run_q <= '0;
            seen_on_q <= 1'b0;
        end else begin
            seen_on_q <= seen_on_q | hs_o | ls_o;
            if (hs_o || ls_o)              low_run_q <= '0;
            else if (low_run_q != LOW_MAX) low_run_q <= low_run_q + 1'b1;
        end
    end

    // R9: never both on.
    p_no_overlap_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(hs_o && ls_o));

    // R9: a turn-on after a turn-off waits the full gap.
    p_gap_before_on_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (($rose(hs_o) || $rose(ls_o)) && seen_on_q) |-> (low_run_q == LOW_MAX));

endmodule

// File: rtl/tristate_pwm_gate.sv
// Module: top of the tri-state PWM gate decoder.
// Synchronises the comparator flags, tracks level and tri-state, applies the
// enables and drives the gates through the break-before-make stage.
// Assumes enable_i and ls_enable_i are synchronous to clk.
module tristate_pwm_gate #(
    parameter int HOLD_CYCLES = 13,
    parameter int DEAD_CYCLES = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic above_i,
    input  logic below_i,
    input  logic enable_i,
    input  logic ls_enable_i,
    output logic hs_gate_o,
    output logic ls_gate_o,
    output logic tri_off_o
);

    logic [1:0] flags_s;
    logic       last_hi;
    logic       req_hs;
    logic       req_ls;

    tsd_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({above_i, below_i}),
        .sync_o  (flags_s)
    );

    tsd_level_track #(.HOLD_CYCLES(HOLD_CYCLES)) u_track (
        .clk       (clk),
        .rst_n     (rst_n),
        .above_s   (flags_s[1]),
        .below_s   (flags_s[0]),
        .tri_off_o (tri_off_o),
        .last_hi_o (last_hi)
    );

    // Turn the tracked level into gate requests under the enables.
    always_comb begin
        req_hs = enable_i && !tri_off_o && last_hi;
        req_ls = enable_i && !tri_off_o && !last_hi && ls_enable_i;
    end

    tsd_deadtime #(.DEAD_CYCLES(DEAD_CYCLES)) u_dead (
        .clk      (clk),
        .rst_n    (rst_n),
        .req_hs_i (req_hs),
        .req_ls_i (req_ls),
        .hs_o     (hs_gate_o),
        .ls_o     (ls_gate_o)
    );

    // R8: global disable leaves both gates off.
    p_enable_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(enable_i) |-> (!hs_gate_o && !ls_gate_o));

    // R7: low-side disable leaves the low-side gate off.
    p_ls_block_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(ls_enable_i) |-> !ls_gate_o);

    // R3: a settled tri-state condition keeps both gates off.
    p_tri_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (tri_off_o && $past(tri_off_o)) |-> (!hs_gate_o && !ls_gate_o));

endmodule

// File: tb/tristate_pwm_gate_tb_top.sv
`timescale 1ns/1ps
module tristate_pwm_gate_tb_top;

    localparam int HOLD = 5;
    localparam int DEAD = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic above = 1'b0, below = 1'b0, en = 1'b0, lsen = 1'b0;
    logic hs, ls, trio;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    tristate_pwm_gate #(.HOLD_CYCLES(HOLD), .DEAD_CYCLES(DEAD), .SYNC_STAGES(2)) dut_i (
        .clk(clk), .rst_n(rst_n), .above_i(above), .below_i(below),
        .enable_i(en), .ls_enable_i(lsen),
        .hs_gate_o(hs), .ls_gate_o(ls), .tri_off_o(trio)
    );

    // Behavioural reference state.
    bit [1:0] pipe[$];
    bit m_tri, m_last_hi, m_hs, m_ls;
    int m_dwell, m_gap;

    task automatic model_reset();
        pipe = {2'b00, 2'b00};
        m_tri = 1; m_last_hi = 0; m_hs = 0; m_ls = 0; m_dwell = 0; m_gap = 0;
    endtask

    // One clock edge of the reference, from the inputs present at that edge.
    task automatic model_edge(bit h, bit l, bit e, bit s);
        bit rh, rl;
        bit [1:0] lv;
        rh = e && !m_tri && m_last_hi;
        rl = e && !m_tri && !m_last_hi && s;
        if ((m_hs && !rh) || (m_ls && !rl)) begin
            m_hs = 0; m_ls = 0; m_gap = DEAD - 1;
        end else if (!m_hs && !m_ls) begin
            if (m_gap > 0) m_gap--;
            else if (rh) m_hs = 1;
            else if (rl) m_ls = 1;
        end
        lv = pipe[0];
        if (lv[1]) begin
            m_tri = 0; m_last_hi = 1; m_dwell = 0;
        end else if (lv[0]) begin
            m_last_hi = 0; m_dwell = 0;
        end else begin
            if (m_dwell == HOLD - 1) m_tri = 1;
            else m_dwell++;
        end
        void'(pipe.pop_front());
        pipe.push_back({h, l});
    endtask

    task automatic check(string tag, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", tag, what, act, exp, $time);
        end
    endtask

    // Drive at the falling edge, advance one cycle, compare with the model.
    task automatic step(bit h, bit l, bit e, bit s, string tag);
        above = h; below = l; en = e; lsen = s;
        @(posedge clk);
        model_edge(h, l, e, s);
        @(negedge clk);
        check(tag, "hs_gate", hs, m_hs);
        check(tag, "ls_gate", ls, m_ls);
        check(tag, "tri_off", trio, m_tri);
    endtask

    task automatic run(int n, bit h, bit l, bit e, bit s, string tag);
        for (int i = 0; i < n; i++) step(h, l, e, s, tag);
    endtask

    initial begin
        model_reset();
        repeat (4) @(negedge clk);
        // R6: reset state.
        check("R6", "reset tri_off", trio, 1);
        check("R6", "reset hs", hs, 0);
        check("R6", "reset ls", ls, 0);
        rst_n = 1'b1;

        // R6: low and mid inputs do not leave the power-up off state.
        run(10, 0, 1, 1, 1, "R6");
        run(8, 0, 0, 1, 1, "R6");
        run(10, 0, 1, 1, 1, "R6");
        check("R6", "still off ls", ls, 0);
        check("R6", "still tri", trio, 1);

        // R1 / R10: first valid high releases and drives high side.
        step(1, 0, 1, 1, "R10");
        step(1, 0, 1, 1, "R10");
        step(1, 0, 1, 1, "R10");
        check("R10", "tri cleared on third edge", trio, 0);
        step(1, 0, 1, 1, "R1");
        check("R1", "hs on fourth edge", hs, 1);
        run(6, 1, 0, 1, 1, "R1");

        // R9 / R2: handover to low side with dead time.
        run(12, 0, 1, 1, 1, "R9");
        check("R2", "ls on after low", ls, 1);
        check("R2", "hs off after low", hs, 0);

        // R1: both flags set counts as high.
        run(12, 1, 1, 1, 1, "R1");
        check("R1", "both flags high-side", hs, 1);

        // R4: short mid excursions are ignored.
        run(3, 0, 0, 1, 1, "R4");
        run(2, 1, 0, 1, 1, "R4");
        run(4, 0, 0, 1, 1, "R4");
        run(4, 1, 0, 1, 1, "R4");
        check("R4", "hs held through excursions", hs, 1);
        check("R4", "no tri entry", trio, 0);
        run(10, 0, 1, 1, 1, "R4");
        run(4, 0, 0, 1, 1, "R4");
        run(4, 0, 1, 1, 1, "R4");
        check("R4", "ls held through excursion", ls, 1);

        // R3: full dwell enters tri-state off.
        run(12, 0, 0, 1, 1, "R3");
        check("R3", "tri set", trio, 1);
        check("R3", "hs off", hs, 0);
        check("R3", "ls off", ls, 0);

        // R5: valid low does not release; high does.
        run(12, 0, 1, 1, 1, "R5");
        check("R5", "tri held by low", trio, 1);
        check("R5", "ls off under tri", ls, 0);
        run(8, 1, 0, 1, 1, "R5");
        check("R5", "released by high", trio, 0);

        // R7: low-side disable.
        run(12, 0, 1, 1, 0, "R7");
        check("R7", "ls forced off", ls, 0);
        run(10, 1, 0, 1, 0, "R7");
        check("R7", "hs follows high", hs, 1);
        run(6, 0, 1, 1, 0, "R7");
        run(8, 0, 1, 1, 1, "R7");
        check("R7", "ls resumes", ls, 1);

        // R8: global disable.
        run(6, 0, 1, 0, 1, "R8");
        check("R8", "ls off when disabled", ls, 0);
        run(8, 1, 0, 0, 1, "R8");
        check("R8", "hs off when disabled", hs, 0);
        run(8, 1, 0, 1, 1, "R8");
        check("R8", "hs resumes", hs, 1);

        // R9: random flag patterns against the model.
        for (int i = 0; i < 2000; i++) begin
            int r;
            r = $urandom_range(0, 99);
            step(r[0], r[1], (r > 5), (r < 90), "R9");
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule